// File: doc/BRIEF.md
# Egress VLAN Tag Rewriter

This block sits on the transmit side of one switch port and decides, frame by frame, whether an outgoing frame must carry an 802.1Q-style VLAN tag and which TPID that tag carries. The frame path hands it a one-cycle strobe per frame. With the strobe come the VID the frame was classified to and the kind of tag the frame had on ingress. One cycle later the block presents an insert flag, the 16-bit TPID and the 12-bit VID to splice into the frame. The byte-level splicing is done elsewhere.

Four per-port configuration fields steer the decision. All four are loaded together through a single write strobe.
- The tag mode selects one of four behaviours:
  - never tag;
  - tag unless the frame's VID is the port VID;
  - tag unless the frame's VID is the port VID or the VLAN-unaware VID 0;
  - always tag.
- The TPID select picks among four sources:
  - the C-tag EtherType;
  - the S-tag EtherType;
  - a custom per-port TPID;
  - the custom TPID, except that frames which arrived C-tagged keep the C-tag EtherType.

A standalone port is normally given port VID 4095, and a VLAN-unaware bridged port uses VID 0.

Top module: `vlan_tag_rewriter`

## Requirements
- R1: After reset, out_vld_o and ins_tag_o are 0, tag_tpid_o is 16'h0000 and tag_vid_o is 12'h000. The configuration resets to tag mode 0, TPID select 0, port VID 4095 and custom TPID 16'h88A8, so a first frame with no configuration write goes out untagged with TPID 16'h8100.
- R2: out_vld_o is high in exactly the cycle after a cycle in which frm_vld_i was sampled high. tag_vid_o then equals the frm_vid_i sampled with that strobe.
- R3: Tag mode 0 (disabled): ins_tag_o is 0 for every frame.
- R4: Tag mode 1: ins_tag_o is 0 when the frame VID equals the port VID, and 1 otherwise.
- R5: Tag mode 2: ins_tag_o is 0 when the frame VID equals the port VID or equals 0, and 1 otherwise.
- R6: Tag mode 3: ins_tag_o is 1 for every frame.
- R7: TPID select 0 gives tag_tpid_o = 16'h8100, and select 1 gives 16'h88A8, whatever the ingress tag kind.
- R8: TPID select 2 gives tag_tpid_o equal to the configured custom TPID, whatever the ingress tag kind.
- R9: TPID select 3 gives 16'h8100 when frm_in_tag_i is 1 (ingress C-tag), and the custom TPID when frm_in_tag_i is 0 (untagged), 2 (S-tag) or 3 (reserved, treated as untagged).
- R10: cfg_wr_i sampled high at an edge loads all four configuration fields at that edge. A frame strobed at that same edge is decided with the previous configuration, and frames strobed at later edges use the new one.
- R11: Between strobes, ins_tag_o, tag_tpid_o and tag_vid_o hold the last decision while out_vld_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Loads all configuration fields |
| cfg_tag_mode_i | input | 2 | Tag mode: 0 off, 1 skip port VID, 2 skip port VID and VID 0, 3 all |
| cfg_tpid_sel_i | input | 2 | TPID select: 0 C-tag, 1 S-tag, 2 custom, 3 custom unless ingress C-tag |
| cfg_port_vid_i | input | 12 | Port VID |
| cfg_port_tpid_i | input | 16 | Custom port TPID |
| frm_vld_i | input | 1 | One-cycle strobe per frame |
| frm_vid_i | input | 12 | Classified VID of the frame |
| frm_in_tag_i | input | 2 | Ingress tag kind: 0 none, 1 C-tag, 2 S-tag, 3 reserved |
| out_vld_o | output | 1 | Decision valid, one cycle after the strobe |
| ins_tag_o | output | 1 | Insert a tag |
| tag_tpid_o | output | 16 | TPID for the inserted tag |
| tag_vid_o | output | 12 | VID for the inserted tag |

## Verification
Three port configurations are each crossed with every tag mode, every TPID select, every ingress tag code and a set of frame VIDs. The port configurations are port VID 5, port VID 4095 and port VID 0, each with a distinct custom TPID. The VIDs 0, 1, 5, 100 and 4095 hit the port VID, the unaware VID and neither, so the sweep separates mode 1 from mode 2 exactly on VID 0 when the port VID is not 0. It also separates select 2 from select 3 exactly on C-tagged ingress. Further stimulus drives a configuration write in the same cycle as a frame strobe, and leaves idle gaps to show that the old configuration is used and that the outputs hold.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  typedef enum logic [1:0] {
    TAG_OFF          = 2'd0,
    TAG_NO_PVID      = 2'd1,
    TAG_NO_PVID_UNAW = 2'd2,
    TAG_ALL          = 2'd3
  } tag_mode_e;

  typedef enum logic [1:0] {
    TPID_CTAG   = 2'd0,
    TPID_STAG   = 2'd1,
    TPID_CUSTOM = 2'd2,
    TPID_KEEP_C = 2'd3
  } tpid_sel_e;

  typedef enum logic [1:0] {
    IN_NONE = 2'd0,
    IN_CTAG = 2'd1,
    IN_STAG = 2'd2,
    IN_RSVD = 2'd3
  } in_tag_e;
endpackage

// File: rtl/vtag_cfg_regs.sv
module vtag_cfg_regs
  import vtag_pkg::*;
#(
  parameter int unsigned       VID_W    = 12,
  parameter int unsigned       TPID_W   = 16,
  parameter logic [VID_W-1:0]  RST_VID  = '1,
  parameter logic [TPID_W-1:0] RST_TPID = 16'h88A8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        sel_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [TPID_W-1:0] tpid_i,
  output tag_mode_e         mode_o,
  output tpid_sel_e         sel_o,
  output logic [VID_W-1:0]  vid_o,
  output logic [TPID_W-1:0] tpid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= TAG_OFF;
      sel_o  <= TPID_CTAG;
      vid_o  <= RST_VID;
      tpid_o <= RST_TPID;
    end else if (wr_i) begin
      mode_o <= tag_mode_e'(mode_i);
      sel_o  <= tpid_sel_e'(sel_i);
      vid_o  <= vid_i;
      tpid_o <= tpid_i;
    end
  end
endmodule

// File: rtl/vtag_mode_dec.sv
module vtag_mode_dec
  import vtag_pkg::*;
#(
  parameter int unsigned      VID_W       = 12,
  parameter logic [VID_W-1:0] UNAWARE_VID = '0
) (
  input  tag_mode_e        mode_i,
  input  logic [VID_W-1:0] frm_vid_i,
  input  logic [VID_W-1:0] port_vid_i,
  output logic             insert_o
);
  logic hit_pvid, hit_unaw;

  assign hit_pvid = (frm_vid_i == port_vid_i);
  assign hit_unaw = (frm_vid_i == UNAWARE_VID);

  always_comb begin
    unique case (mode_i)
      TAG_OFF:          insert_o = 1'b0;
      TAG_NO_PVID:      insert_o = !hit_pvid;
      TAG_NO_PVID_UNAW: insert_o = !(hit_pvid || hit_unaw);
      TAG_ALL:          insert_o = 1'b1;
      default:          insert_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/vtag_tpid_sel.sv
module vtag_tpid_sel
  import vtag_pkg::*;
#(
  parameter int unsigned       TPID_W    = 16,
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100,
  parameter logic [TPID_W-1:0] STAG_TPID = 16'h88A8
) (
  input  tpid_sel_e         sel_i,
  input  logic [1:0]        in_tag_i,
  input  logic [TPID_W-1:0] custom_i,
  output logic [TPID_W-1:0] tpid_o
);
  logic was_ctag;

  assign was_ctag = (in_tag_e'(in_tag_i) == IN_CTAG);

  always_comb begin
    unique case (sel_i)
      TPID_CTAG:   tpid_o = CTAG_TPID;
      TPID_STAG:   tpid_o = STAG_TPID;
      TPID_CUSTOM: tpid_o = custom_i;
      TPID_KEEP_C: tpid_o = was_ctag ? CTAG_TPID : custom_i;
      default:     tpid_o = CTAG_TPID;
    endcase
  end
endmodule

// File: rtl/vlan_tag_rewriter.sv
module vlan_tag_rewriter
  import vtag_pkg::*;
#(
  parameter int unsigned       VID_W       = 12,
  parameter int unsigned       TPID_W      = 16,
  parameter logic [TPID_W-1:0] CTAG_TPID   = 16'h8100,
  parameter logic [TPID_W-1:0] STAG_TPID   = 16'h88A8,
  parameter logic [VID_W-1:0]  UNAWARE_VID = '0,
  parameter logic [VID_W-1:0]  RST_VID     = '1,
  parameter logic [TPID_W-1:0] RST_TPID    = 16'h88A8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_tag_mode_i,
  input  logic [1:0]        cfg_tpid_sel_i,
  input  logic [VID_W-1:0]  cfg_port_vid_i,
  input  logic [TPID_W-1:0] cfg_port_tpid_i,
  input  logic              frm_vld_i,
  input  logic [VID_W-1:0]  frm_vid_i,
  input  logic [1:0]        frm_in_tag_i,
  output logic              out_vld_o,
  output logic              ins_tag_o,
  output logic [TPID_W-1:0] tag_tpid_o,
  output logic [VID_W-1:0]  tag_vid_o
);
  tag_mode_e         cfg_mode;
  tpid_sel_e         cfg_sel;
  logic [VID_W-1:0]  cfg_vid;
  logic [TPID_W-1:0] cfg_tpid;
  logic              ins_d;
  logic [TPID_W-1:0] tpid_d;

  vtag_cfg_regs #(
    .VID_W   (VID_W),
    .TPID_W  (TPID_W),
    .RST_VID (RST_VID),
    .RST_TPID(RST_TPID)
  ) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (cfg_wr_i),
    .mode_i(cfg_tag_mode_i),
    .sel_i (cfg_tpid_sel_i),
    .vid_i (cfg_port_vid_i),
    .tpid_i(cfg_port_tpid_i),
    .mode_o(cfg_mode),
    .sel_o (cfg_sel),
    .vid_o (cfg_vid),
    .tpid_o(cfg_tpid)
  );

  vtag_mode_dec #(
    .VID_W      (VID_W),
    .UNAWARE_VID(UNAWARE_VID)
  ) u_mode (
    .mode_i    (cfg_mode),
    .frm_vid_i (frm_vid_i),
    .port_vid_i(cfg_vid),
    .insert_o  (ins_d)
  );

  vtag_tpid_sel #(
    .TPID_W   (TPID_W),
    .CTAG_TPID(CTAG_TPID),
    .STAG_TPID(STAG_TPID)
  ) u_tpid (
    .sel_i   (cfg_sel),
    .in_tag_i(frm_in_tag_i),
    .custom_i(cfg_tpid),
    .tpid_o  (tpid_d)
  );

  // Decision registered on the strobe, held until the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      ins_tag_o  <= 1'b0;
      tag_tpid_o <= '0;
      tag_vid_o  <= '0;
    end else begin
      out_vld_o <= frm_vld_i;
      if (frm_vld_i) begin
        ins_tag_o  <= ins_d;
        tag_tpid_o <= tpid_d;
        tag_vid_o  <= frm_vid_i;
      end
    end
  end
endmodule

// File: rtl/vlan_tag_rewriter_chk.sv
module vlan_tag_rewriter_chk
#(
  parameter int unsigned       VID_W     = 12,
  parameter int unsigned       TPID_W    = 16,
  parameter logic [TPID_W-1:0] CTAG_TPID = 16'h8100,
  parameter logic [TPID_W-1:0] STAG_TPID = 16'h88A8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_vld_i,
  input logic [VID_W-1:0]  frm_vid_i,
  input logic [1:0]        frm_in_tag_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        sel_i,
  input logic [VID_W-1:0]  port_vid_i,
  input logic [TPID_W-1:0] port_tpid_i,
  input logic              out_vld_i,
  input logic              ins_i,
  input logic [TPID_W-1:0] tpid_i,
  input logic [VID_W-1:0]  vid_i
);
  p_vld_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> out_vld_i);
  p_vld_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> !out_vld_i);
  p_vid_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> (vid_i == $past(frm_vid_i)));
  p_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && mode_i == 2'd0) |=> !ins_i);
  p_pvid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && mode_i == 2'd1) |=> (ins_i == ($past(frm_vid_i) != $past(port_vid_i))));
  p_unaw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && mode_i == 2'd2 && frm_vid_i == '0) |=> !ins_i);
  p_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && mode_i == 2'd3) |=> ins_i);
  p_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && sel_i[1] == 1'b0) |=> (tpid_i == ($past(sel_i[0]) ? STAG_TPID : CTAG_TPID)));
  p_custom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && sel_i == 2'd2) |=> (tpid_i == $past(port_tpid_i)));
  p_keepc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_vld_i && sel_i == 2'd3 && frm_in_tag_i == 2'd1) |=> (tpid_i == CTAG_TPID));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> ($stable(ins_i) && $stable(tpid_i) && $stable(vid_i)));
endmodule

bind vlan_tag_rewriter vlan_tag_rewriter_chk #(
  .VID_W    (VID_W),
  .TPID_W   (TPID_W),
  .CTAG_TPID(CTAG_TPID),
  .STAG_TPID(STAG_TPID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frm_vld_i   (frm_vld_i),
  .frm_vid_i   (frm_vid_i),
  .frm_in_tag_i(frm_in_tag_i),
  .mode_i      (cfg_mode),
  .sel_i       (cfg_sel),
  .port_vid_i  (cfg_vid),
  .port_tpid_i (cfg_tpid),
  .out_vld_i   (out_vld_o),
  .ins_i       (ins_tag_o),
  .tpid_i      (tag_tpid_o),
  .vid_i       (tag_vid_o)
);

// File: tb/vlan_tag_rewriter_test.sv
module vlan_tag_rewriter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [1:0]  cfg_sel = '0;
  logic [11:0] cfg_vid = '0;
  logic [15:0] cfg_tpid = '0;
  logic        frm_vld = 1'b0;
  logic [11:0] frm_vid = '0;
  logic [1:0]  frm_tag = '0;
  logic        out_vld, ins_tag;
  logic [15:0] tag_tpid;
  logic [11:0] tag_vid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vlan_tag_rewriter uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cfg_wr_i       (cfg_wr),
    .cfg_tag_mode_i (cfg_mode),
    .cfg_tpid_sel_i (cfg_sel),
    .cfg_port_vid_i (cfg_vid),
    .cfg_port_tpid_i(cfg_tpid),
    .frm_vld_i      (frm_vld),
    .frm_vid_i      (frm_vid),
    .frm_in_tag_i   (frm_tag),
    .out_vld_o      (out_vld),
    .ins_tag_o      (ins_tag),
    .tag_tpid_o     (tag_tpid),
    .tag_vid_o      (tag_vid)
  );

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit exp_ins(input int mode, input int vid, input int pvid);
    case (mode)
      0: return 1'b0;
      1: return vid != pvid;
      2: return (vid != pvid) && (vid != 0);
      default: return 1'b1;
    endcase
  endfunction

  function automatic int exp_tpid(input int sel, input int itag, input int cust);
    case (sel)
      0: return 16'h8100;
      1: return 16'h88A8;
      2: return cust;
      default: return (itag == 1) ? 16'h8100 : cust;
    endcase
  endfunction

  function automatic string mode_rq(input int mode);
    case (mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic string sel_rq(input int sel);
    case (sel)
      0, 1: return "R7";
      2: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic write_cfg(input int mode, input int sel, input int vid, input int tpid);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 2'(mode); cfg_sel = 2'(sel);
    cfg_vid = 12'(vid); cfg_tpid = 16'(tpid);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Strobe at a negedge; result is registered at the next posedge, sampled at the next negedge
  task automatic send_frame(input int vid, input int itag);
    @(negedge clk);
    frm_vld = 1'b1; frm_vid = 12'(vid); frm_tag = 2'(itag);
    @(negedge clk);
    frm_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int pvids[3] = '{5, 4095, 0};
    int tpids[3] = '{16'h9100, 16'h88A8, 16'h1234};
    int vids[5]  = '{0, 1, 5, 100, 4095};

    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", "out_vld", out_vld, 0);
    check("R1", "ins_tag", ins_tag, 0);
    check("R1", "tpid", tag_tpid, 0);
    check("R1", "vid", tag_vid, 0);
    rst_n = 1'b1;
    // R1: default config gives untagged, TPID 0x8100
    send_frame(77, 2);
    check("R1", "ins_tag default", ins_tag, 0);
    check("R1", "tpid default", tag_tpid, 16'h8100);
    check("R2", "out_vld after strobe", out_vld, 1);
    check("R2", "vid pass", tag_vid, 77);
    @(negedge clk);
    check("R2", "out_vld idle", out_vld, 0);

    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++) begin
          write_cfg(m, s, pvids[p], tpids[p]);
          for (int v = 0; v < 5; v++)
            for (int t = 0; t < 4; t++) begin
              send_frame(vids[v], t);
              check("R2", "out_vld", out_vld, 1);
              check("R2", "vid", tag_vid, vids[v]);
              check(mode_rq(m), "ins_tag", ins_tag, exp_ins(m, vids[v], pvids[p]));
              check(sel_rq(s), "tpid", tag_tpid, exp_tpid(s, t, tpids[p]));
            end
        end

    // R10: write in the same cycle as a strobe uses old config
    write_cfg(3, 2, 9, 16'hABCD);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = 2'd0; cfg_sel = 2'd1; cfg_vid = 12'd9; cfg_tpid = 16'h1111;
    frm_vld = 1'b1; frm_vid = 12'd9; frm_tag = 2'd0;
    @(negedge clk);
    cfg_wr = 1'b0; frm_vld = 1'b0;
    check("R10", "ins_tag old cfg", ins_tag, 1);
    check("R10", "tpid old cfg", tag_tpid, 16'hABCD);
    send_frame(9, 0);
    check("R10", "ins_tag new cfg", ins_tag, 0);
    check("R10", "tpid new cfg", tag_tpid, 16'h88A8);

    // R11: hold between strobes
    write_cfg(3, 2, 1, 16'h7777);
    send_frame(300, 1);
    for (int i = 0; i < 4; i++) begin
      frm_vid = 12'(i + 50);
      frm_tag = 2'(i);
      @(negedge clk);
      check("R11", "out_vld low", out_vld, 0);
      check("R11", "ins hold", ins_tag, 1);
      check("R11", "tpid hold", tag_tpid, 16'h7777);
      check("R11", "vid hold", tag_vid, 300);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule